// File: doc/BRIEF.md
# Eight-Channel External Interrupt Controller

This block watches eight external request pins and turns activity on them into pending request flags for a processor. Each pin has its own detection mode: low level, high level, rising edge or falling edge. Every pin first passes through a two-flop synchroniser. Detection then runs on the synchronised value. A detected request sets that channel's flag. The flag stays set until software clears it.

Software reaches the block over a small byte-wide register bus. The bus has a two-bit address, a write strobe, a read strobe and a qualifier that marks read-modify-write reads. There are four registers:

| Offset | Contents |
|---|---|
| 0 | Channel enable byte |
| 1 | Pending flags |
| 2 | Detection modes, low byte |
| 3 | Detection modes, high byte |

Flags are cleared by writing zero bits. A level-mode flag sets itself again while its input stays active. The interrupt output goes high when any enabled channel has a pending flag.

Each channel is a two-state machine:
- **CH_IDLE**: no request is pending. The transition CH_IDLE→CH_PENDING ("detect") fires on any cycle in which the channel's detector is true.
- **CH_PENDING**: the flag reads as 1. The transition CH_PENDING→CH_IDLE ("clear") fires only when software writes a zero to that flag bit in a cycle where the detector is false.
- In every other case a channel stays in its state.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Reading offset 1 with the read strobe high and the read-modify-write qualifier low returns the pending flags. Bit n is 1 exactly when channel n (0 to 7) has a pending request.
- R2: A write to offset 1 clears every flag whose data bit is 0. Flags whose data bit is 1 keep their value.
- R3: A read of offset 1 with the read-modify-write qualifier high returns 8'hFF, whatever the flags hold.
- R4: Channel n takes its two-bit mode from bits 2n (low bit) and 2n+1 (high bit) of the 16-bit mode value. Offset 2 holds bits 7:0 of that value and offset 3 holds bits 15:8. The mode encodings are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R5: In a level mode, a flag cleared while its synchronised input is at the active level is set again, so it still reads 1 afterwards.
- R6: In an edge mode, a pin change made between clock edges shows as a set flag after the third rising clock edge that follows, and not after the second.
- R7: If a detection and a write-zero clear reach the same flag in the same cycle, the flag ends up set.
- R8: The interrupt output is high exactly when some channel has both its flag and its enable bit (offset 0, bit n) set. Flags still set when their channel is disabled.
- R9: After reset the enable and mode registers read 0 and the interrupt output is low. The read data is 0 whenever the read strobe is low.
- R10: Values written to offsets 0, 2 and 3 read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pin | input | 8 | Asynchronous external request pins |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks a read as part of a read-modify-write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| irq | output | 1 | Combined interrupt request |

## Verification
A channel state machine stuck in CH_PENDING or CH_IDLE shows at the flag read and on irq in the same cycle. A wrong choice between clear and re-detect shows on the first read after the clearing write. A detector that decodes the wrong mode bits, or a synchroniser of the wrong depth, moves the cycle in which the flag appears. That shift is visible on a read three edges after a pin change. The vector table exercises each mode under several pin patterns. The directed tests pin down the exact latency and the same-cycle collision between set and clear.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int NUM_CH = 8;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;
    localparam int MODE_W = 2 * NUM_CH;

    localparam logic [ADDR_W-1:0] A_ENABLE  = 2'd0;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 2'd1;
    localparam logic [ADDR_W-1:0] A_MODE_LO = 2'd2;
    localparam logic [ADDR_W-1:0] A_MODE_HI = 2'd3;

    typedef enum logic [1:0] {
        DET_LOW  = 2'b00,
        DET_HIGH = 2'b01,
        DET_RISE = 2'b10,
        DET_FALL = 2'b11
    } det_mode_t;

    typedef enum logic {
        CH_IDLE    = 1'b0,
        CH_PENDING = 1'b1
    } ch_state_t;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= '0;
            end
        end else begin
            stage_q[0] <= din;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/ext_irq_channel.sv
module ext_irq_channel
    import ext_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_s,
    input  det_mode_t mode,
    input  logic      clr,
    output logic      det,
    output logic      pend
);

    logic      prev_q;
    ch_state_t state_q;
    ch_state_t state_d;

    // Previous synchronised value, used by the edge detectors.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
        end
    end

    always_comb begin
        det = 1'b0;
        unique case (mode)
            DET_LOW:  det = ~pin_s;
            DET_HIGH: det = pin_s;
            DET_RISE: det = pin_s & ~prev_q;
            DET_FALL: det = ~pin_s & prev_q;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a detection always beats a clear.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (det) state_d = CH_PENDING;
            end
            CH_PENDING: begin
                if (clr && !det) state_d = CH_IDLE;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        pend = (state_q == CH_PENDING);
    end

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_rmw,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [NUM_CH-1:0] pend,
    output logic [NUM_CH-1:0] en_q,
    output logic [MODE_W-1:0] mode_q,
    output logic [NUM_CH-1:0] clr,
    output logic [BUS_W-1:0]  bus_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_ENABLE:  en_q <= bus_wdata[NUM_CH-1:0];
                A_MODE_LO: mode_q[BUS_W-1:0] <= bus_wdata;
                A_MODE_HI: mode_q[MODE_W-1 -: BUS_W] <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Zero bits of a flag write become per-channel clear strobes.
    always_comb begin
        clr = '0;
        if (bus_wr && bus_addr == A_FLAGS) begin
            clr = ~bus_wdata[NUM_CH-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_ENABLE:  bus_rdata = en_q;
                A_FLAGS:   bus_rdata = bus_rmw ? '1 : pend;
                A_MODE_LO: bus_rdata = mode_q[BUS_W-1:0];
                A_MODE_HI: bus_rdata = mode_q[MODE_W-1 -: BUS_W];
            endcase
        end
    end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_rmw,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);

    logic [NUM_CH-1:0] pin_s;
    logic [NUM_CH-1:0] flag_q;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] det;
    logic [MODE_W-1:0] mode_q;

    ext_irq_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (req_pin),
        .dout  (pin_s)
    );

    ext_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rmw   (bus_rmw),
        .bus_wdata (bus_wdata),
        .pend      (flag_q),
        .en_q      (en_q),
        .mode_q    (mode_q),
        .clr       (clr),
        .bus_rdata (bus_rdata)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        ext_irq_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_s (pin_s[ch]),
            .mode  (det_mode_t'(mode_q[2*ch +: 2])),
            .clr   (clr[ch]),
            .det   (det[ch]),
            .pend  (flag_q[ch])
        );
    end

    assign irq = |(flag_q & en_q);

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
    import ext_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_rmw,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              irq,
    input logic [NUM_CH-1:0] flag_q,
    input logic [NUM_CH-1:0] en_q,
    input logic [NUM_CH-1:0] det
);

    // Becomes 1 one edge after reset is released, so $past never reaches into reset.
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        (bus_wr && bus_addr == A_FLAGS) |=>
            ((flag_q & $past(flag_q) & $past(bus_wdata)) == ($past(flag_q) & $past(bus_wdata)))); // R2

    AST_RMW_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_rmw && bus_addr == A_FLAGS) |-> (bus_rdata == 8'hFF)); // R3

    AST_FLAG_NEEDS_DETECT: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        ((flag_q & ~$past(flag_q) & ~$past(det)) == '0)); // R6

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        ((flag_q & $past(det)) == $past(det))); // R7

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_q != '0)); // R8

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0)); // R9

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rmw   (bus_rmw),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .flag_q    (flag_q),
    .en_q      (en_q),
    .det       (det)
);

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_pin = 8'h00;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_rmw = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] rd;

    always #2 clk = ~clk;   // 250 MHz

    ext_irq_ctrl u_ext_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_pin   (req_pin),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rmw   (bus_rmw),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // {mode[15:0], pins before clear, pins after clear, expected flags}
    localparam logic [39:0] VEC [5] = '{
        {16'h0000, 8'hFF, 8'h0F, 8'hF0},   // all low level
        {16'h5555, 8'h00, 8'h3C, 8'h3C},   // all high level
        {16'hAAAA, 8'h0F, 8'hFF, 8'hF0},   // all rising edge
        {16'hFFFF, 8'hFF, 8'hA5, 8'h5A},   // all falling edge
        {16'hE4E4, 8'hB9, 8'h55, 8'hEC}    // channel n uses mode n mod 4
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic rmw, output logic [7:0] d);
        bus_addr = a; bus_rmw = rmw; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0; bus_rmw = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 idle rdata", bus_rdata, 8'h00);
        check("R9 irq after reset", {7'd0, irq}, 8'h00);
        bus_read(2'd0, 1'b0, rd); check("R9 enable reset", rd, 8'h00);
        bus_read(2'd2, 1'b0, rd); check("R9 mode lo reset", rd, 8'h00);
        bus_read(2'd3, 1'b0, rd); check("R9 mode hi reset", rd, 8'h00);
        // R4 / R5: default mode is low level and pins are low, so every flag sets
        wait_cyc(4);
        bus_read(2'd1, 1'b0, rd); check("R4 low-level default sets all flags", rd, 8'hFF);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, 1'b0, rd); check("R5 level flags re-arm after clear", rd, 8'hFF);

        // Vector table: R1, R4, R5, R6, R10
        for (int i = 0; i < 5; i++) begin
            bus_write(2'd2, VEC[i][31:24]);
            bus_write(2'd3, VEC[i][39:32]);
            bus_read(2'd2, 1'b0, rd); check("R10 mode lo readback", rd, VEC[i][31:24]);
            bus_read(2'd3, 1'b0, rd); check("R10 mode hi readback", rd, VEC[i][39:32]);
            req_pin = VEC[i][23:16];
            wait_cyc(6);
            bus_write(2'd1, 8'h00);
            req_pin = VEC[i][15:8];
            wait_cyc(6);
            bus_read(2'd1, 1'b0, rd);
            check($sformatf("R1 R4 vector %0d flags", i), rd, VEC[i][7:0]);
        end

        // Enables and interrupt output: R8, R10
        bus_write(2'd2, 8'hAA);
        bus_write(2'd3, 8'hAA);
        req_pin = 8'h00;
        wait_cyc(6);
        bus_write(2'd1, 8'h00);
        req_pin = 8'h0F;
        wait_cyc(6);
        bus_read(2'd1, 1'b0, rd); check("R8 flags set while disabled", rd, 8'h0F);
        check("R8 irq low with no enables", {7'd0, irq}, 8'h00);
        bus_write(2'd0, 8'hF0);
        check("R8 irq low, enables miss flags", {7'd0, irq}, 8'h00);
        bus_write(2'd0, 8'h11);
        check("R8 irq high, enabled flag", {7'd0, irq}, 8'h01);
        bus_read(2'd0, 1'b0, rd); check("R10 enable readback", rd, 8'h11);
        bus_write(2'd1, 8'hFE);
        check("R8 irq low after clearing enabled flag", {7'd0, irq}, 8'h00);

        // Write-one has no effect, partial clear, read-modify-write: R2, R3
        bus_read(2'd1, 1'b0, rd); check("R2 zero bit cleared only", rd, 8'h0E);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, 1'b0, rd); check("R2 write of ones keeps flags", rd, 8'h0E);
        bus_write(2'd1, 8'hF3);
        bus_read(2'd1, 1'b0, rd); check("R2 partial clear", rd, 8'h02);
        bus_read(2'd1, 1'b1, rd); check("R3 rmw read all ones", rd, 8'hFF);
        bus_read(2'd1, 1'b0, rd); check("R1 plain read after rmw", rd, 8'h02);

        // Edge latency on channel 4 (rising mode): R6
        @(negedge clk);
        req_pin[4] = 1'b1;                 // change before edge 1
        @(negedge clk);
        bus_read(2'd1, 1'b0, rd); check("R6 not set after edge 1", rd & 8'h10, 8'h00);
        @(negedge clk);
        bus_read(2'd1, 1'b0, rd); check("R6 not set after edge 2", rd & 8'h10, 8'h00);
        @(negedge clk);
        bus_read(2'd1, 1'b0, rd); check("R6 set after edge 3", rd & 8'h10, 8'h10);

        // Set and clear colliding on channel 5: R7
        @(negedge clk);
        req_pin[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 8'hDF; bus_wr = 1'b1;   // clear meets detection
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(2'd1, 1'b0, rd); check("R7 set wins over clear", rd & 8'h20, 8'h20);
        bus_write(2'd1, 8'hDF);
        bus_read(2'd1, 1'b0, rd); check("R2 later clear takes effect", rd & 8'h20, 8'h00);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule